// File: doc/BRIEF.md
# External Bus Cycle Generator

This block turns one internal request into one asynchronous read or write cycle on an external parallel bus for a single chip-select region. The internal side offers an address, write data and a direction flag; once the cycle is over the block returns a one-clock completion pulse and, for reads, the captured data word. The external side gets an active-low chip enable, separate active-low read and write strobes, an address, write data with its own drive enable, and an active-low acknowledge line.

The cycle runs in five phases, always in the same order. An optional address lead comes first, with chip enable still high. An optional setup interval follows, with chip enable low before the strobe. Then comes the strobe, a hold interval with the strobe released but chip enable still low, and a recovery gap before the block goes idle. Each phase length comes from its own configuration field, scaled by a common factor chosen with a 2-bit code. In ready mode the strobe is held for as long as a synchronized device ready input stays low. After ready returns, the strobe can be held a further programmable number of clocks.

The configuration inputs are static while a cycle runs. Requests arrive on a valid line and are taken only while the block is idle and the region is enabled.

Top module: `extbus_cycle_gen`

## Requirements
- R1: The scale code selects the clock multiplier m: code 0 gives 4, code 1 gives 1, code 2 gives 2 and code 3 gives 8. `busy` is high for exactly A+C+T+H+G clocks per cycle. Here A = lead·m, C = setup·m, T = strobe clocks including the ready stretch, H = (tail+1)·m and G = (gap+1)·m.
- R2: Chip enable is low for exactly C+T+H consecutive clocks and never outside a cycle. The address lead phase (chip enable high) is skipped when the lead field is 0, and the setup phase is skipped when the setup field is 0.
- R3: A read drives only the read strobe, for (rd_pulse+1)·m clocks, and uses rd_tail for the hold. A write drives only the write strobe, for (wr_pulse+1)·m clocks, and uses wr_tail for the hold. The other strobe stays high for the whole cycle.
- R4: With ready mode on, the ready input passes through a two-flop synchronizer. If ready is raised during strobe clock k (counting from 0), the strobe lasts max(S, k+3) clocks plus rdy_tail·m further clocks, where S is the programmed strobe length.
- R5: With ready mode off, the ready input has no effect, even if it is held low for the whole cycle.
- R6: Read data is taken from `bus_din` at the clock edge that releases the read strobe. `rdata` keeps that value until the next read completes; writes leave it unchanged.
- R7: `done` is a single-clock pulse in the first clock of the recovery gap, exactly one per cycle.
- R8: On writes, `bus_doe` is high exactly while chip enable is low, and `bus_dout` carries the request's write data throughout. On reads `bus_doe` stays low.
- R9: `bus_addr` carries the accepted request address during every busy clock.
- R10: While `cfg_region_en` is low, a request starts nothing: busy, chip enable and done stay inactive.
- R11: `bus_ack_n` stays high when `cfg_ack_en` is clear. When it is set, `bus_ack_n` is low exactly while chip enable is low.
- R12: A request presented while busy is ignored. It does not change the address or direction of the running cycle, and no cycle follows once busy falls.
- R13: After reset the block is idle: busy, done and bus_doe are low; chip enable, both strobes and acknowledge are high; rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_region_en | input | 1 | Region enable; requests are ignored when low |
| cfg_ack_en | input | 1 | Drive the acknowledge line during chip enable |
| cfg_scale | input | 2 | Multiplier code (0:×4, 1:×1, 2:×2, 3:×8) |
| cfg_rdy_en | input | 1 | Stretch the strobe on a low ready input |
| cfg_lead | input | FIELD_W | Address lead clocks before chip enable (×m) |
| cfg_setup | input | FIELD_W | Chip enable to strobe clocks (×m) |
| cfg_rd_pulse | input | FIELD_W | Read strobe length minus one (×m) |
| cfg_wr_pulse | input | FIELD_W | Write strobe length minus one (×m) |
| cfg_rd_tail | input | FIELD_W | Read hold length minus one (×m) |
| cfg_wr_tail | input | FIELD_W | Write hold length minus one (×m) |
| cfg_gap | input | FIELD_W | Recovery gap length minus one (×m) |
| cfg_rdy_tail | input | FIELD_W | Extra strobe clocks after ready returns (×m) |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DATA_W | Last read data |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_ack_n | output | 1 | Acknowledge, active low |
| bus_addr | output | ADDR_W | Bus address |
| bus_dout | output | DATA_W | Write data to the bus |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | DATA_W | Read data from the bus |
| bus_ready | input | 1 | Device ready, asynchronous |

## Verification
The bench uses the default parameters: 16-bit address and data and 4-bit timing fields. With these, even the longest phase at the ×8 code is only 128 clocks, so all four scale codes can be swept in both directions across several field sets. The sets include zero lead and zero setup, which exercise the skipped phases. The ready stretch is checked with ready released both before and after the programmed strobe end, which exposes the two synchronizer clocks in the strobe count.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_LEAD   = 3'd1,
        PH_SETUP  = 3'd2,
        PH_STROBE = 3'd3,
        PH_EXTEND = 3'd4,
        PH_HOLD   = 3'd5,
        PH_GAP    = 3'd6
    } phase_e;

    localparam int SCALE_W = 4;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic ack_n;
        logic doe;
    } pins_t;

    function automatic logic [SCALE_W-1:0] scale_factor(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd4;
            2'd1:    return 4'd1;
            2'd2:    return 4'd2;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic in_select(input phase_e ph);
        return (ph == PH_SETUP) || (ph == PH_STROBE) ||
               (ph == PH_EXTEND) || (ph == PH_HOLD);
    endfunction

    function automatic logic in_strobe(input phase_e ph);
        return (ph == PH_STROBE) || (ph == PH_EXTEND);
    endfunction

endpackage

// File: rtl/ebc_sync.sv
module ebc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= RST_VAL;
                else     chain[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= RST_VAL;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ebc_phase_timer.sv
module ebc_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
    end

    assign expired = (cnt_q == '0);

    AST_TMR_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q == '0) |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
    import ebc_pkg::*;
#(
    parameter int FIELD_W = 4,
    localparam int CNT_W  = FIELD_W + SCALE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               req_write,
    input  logic [1:0]         cfg_scale,
    input  logic               cfg_rdy_en,
    input  logic [FIELD_W-1:0] cfg_lead,
    input  logic [FIELD_W-1:0] cfg_setup,
    input  logic [FIELD_W-1:0] cfg_rd_pulse,
    input  logic [FIELD_W-1:0] cfg_wr_pulse,
    input  logic [FIELD_W-1:0] cfg_rd_tail,
    input  logic [FIELD_W-1:0] cfg_wr_tail,
    input  logic [FIELD_W-1:0] cfg_gap,
    input  logic [FIELD_W-1:0] cfg_rdy_tail,
    input  logic               rdy_s,
    input  logic               tmr_zero,
    output logic               tmr_load,
    output logic [CNT_W-1:0]   tmr_val,
    output phase_e             ph,
    output logic               wr,
    output logic               finish,
    output logic               capture
);
    phase_e ph_q, ph_d;
    logic   wr_q;
    logic   wr_eff;
    logic   stall;

    function automatic logic [CNT_W-1:0] span(input logic [FIELD_W-1:0] f,
                                               input logic plus1,
                                               input logic [1:0] code);
        logic [CNT_W-1:0] base;
        base = CNT_W'(f) + CNT_W'(plus1);
        return base * CNT_W'(scale_factor(code));
    endfunction

    assign wr_eff = (ph_q == PH_IDLE) ? req_write : wr_q;
    assign stall  = cfg_rdy_en && !rdy_s;

    always_comb begin
        ph_d    = ph_q;
        finish  = 1'b0;
        capture = 1'b0;
        case (ph_q)
            PH_IDLE:
                if (start)
                    ph_d = (cfg_lead != '0)  ? PH_LEAD :
                           (cfg_setup != '0) ? PH_SETUP : PH_STROBE;
            PH_LEAD:
                if (tmr_zero)
                    ph_d = (cfg_setup != '0) ? PH_SETUP : PH_STROBE;
            PH_SETUP:
                if (tmr_zero) ph_d = PH_STROBE;
            PH_STROBE:
                if (tmr_zero && !stall)
                    ph_d = (cfg_rdy_en && cfg_rdy_tail != '0) ? PH_EXTEND : PH_HOLD;
            PH_EXTEND:
                if (tmr_zero) ph_d = PH_HOLD;
            PH_HOLD:
                if (tmr_zero) begin
                    ph_d   = PH_GAP;
                    finish = 1'b1;
                end
            PH_GAP:
                if (tmr_zero) ph_d = PH_IDLE;
            default:
                ph_d = PH_IDLE;
        endcase
        if (in_strobe(ph_q) && ph_d == PH_HOLD && !wr_q) capture = 1'b1;
    end

    always_comb begin
        tmr_load = (ph_d != ph_q);
        case (ph_d)
            PH_LEAD:   tmr_val = span(cfg_lead, 1'b0, cfg_scale) - CNT_W'(1);
            PH_SETUP:  tmr_val = span(cfg_setup, 1'b0, cfg_scale) - CNT_W'(1);
            PH_STROBE: tmr_val = span(wr_eff ? cfg_wr_pulse : cfg_rd_pulse, 1'b1, cfg_scale) - CNT_W'(1);
            PH_EXTEND: tmr_val = span(cfg_rdy_tail, 1'b0, cfg_scale) - CNT_W'(1);
            PH_HOLD:   tmr_val = span(wr_eff ? cfg_wr_tail : cfg_rd_tail, 1'b1, cfg_scale) - CNT_W'(1);
            PH_GAP:    tmr_val = span(cfg_gap, 1'b1, cfg_scale) - CNT_W'(1);
            default:   tmr_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_IDLE;
            wr_q <= 1'b0;
        end else begin
            ph_q <= ph_d;
            if (ph_q == PH_IDLE && start) wr_q <= req_write;
        end
    end

    assign ph = ph_q;
    assign wr = wr_q;

    AST_RDY_STALL: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_STROBE && tmr_zero && cfg_rdy_en && !rdy_s) |=> (ph_q == PH_STROBE)); // R4
endmodule

// File: rtl/extbus_cycle_gen.sv
module extbus_cycle_gen
    import ebc_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int FIELD_W     = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = FIELD_W + SCALE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_region_en,
    input  logic               cfg_ack_en,
    input  logic [1:0]         cfg_scale,
    input  logic               cfg_rdy_en,
    input  logic [FIELD_W-1:0] cfg_lead,
    input  logic [FIELD_W-1:0] cfg_setup,
    input  logic [FIELD_W-1:0] cfg_rd_pulse,
    input  logic [FIELD_W-1:0] cfg_wr_pulse,
    input  logic [FIELD_W-1:0] cfg_rd_tail,
    input  logic [FIELD_W-1:0] cfg_wr_tail,
    input  logic [FIELD_W-1:0] cfg_gap,
    input  logic [FIELD_W-1:0] cfg_rdy_tail,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               busy,
    output logic               done,
    output logic [DATA_W-1:0]  rdata,
    output logic               bus_ce_n,
    output logic               bus_oe_n,
    output logic               bus_we_n,
    output logic               bus_ack_n,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_dout,
    output logic               bus_doe,
    input  logic [DATA_W-1:0]  bus_din,
    input  logic               bus_ready
);
    phase_e             ph;
    logic               wr;
    logic               rdy_s;
    logic               tmr_zero;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               finish;
    logic               capture;
    logic               start;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [DATA_W-1:0]  rdata_q;
    logic               done_q;
    pins_t              pins;

    assign start = req_valid && cfg_region_en && (ph == PH_IDLE);

    ebc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_ready),
        .q   (rdy_s)
    );

    ebc_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    ebc_seq #(.FIELD_W(FIELD_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .req_write    (req_write),
        .cfg_scale    (cfg_scale),
        .cfg_rdy_en   (cfg_rdy_en),
        .cfg_lead     (cfg_lead),
        .cfg_setup    (cfg_setup),
        .cfg_rd_pulse (cfg_rd_pulse),
        .cfg_wr_pulse (cfg_wr_pulse),
        .cfg_rd_tail  (cfg_rd_tail),
        .cfg_wr_tail  (cfg_wr_tail),
        .cfg_gap      (cfg_gap),
        .cfg_rdy_tail (cfg_rdy_tail),
        .rdy_s        (rdy_s),
        .tmr_zero     (tmr_zero),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .ph           (ph),
        .wr           (wr),
        .finish       (finish),
        .capture      (capture)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            if (start) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) rdata_q <= bus_din;
            done_q <= finish;
        end
    end

    always_comb begin
        pins.ce_n  = !in_select(ph);
        pins.oe_n  = !(in_strobe(ph) && !wr);
        pins.we_n  = !(in_strobe(ph) && wr);
        pins.ack_n = !(cfg_ack_en && in_select(ph));
        pins.doe   = in_select(ph) && wr;
    end

    assign busy      = (ph != PH_IDLE);
    assign done      = done_q;
    assign rdata     = rdata_q;
    assign bus_ce_n  = pins.ce_n;
    assign bus_oe_n  = pins.oe_n;
    assign bus_we_n  = pins.we_n;
    assign bus_ack_n = pins.ack_n;
    assign bus_doe   = pins.doe;
    assign bus_addr  = addr_q;
    assign bus_dout  = wdata_q;

    AST_STB_IN_CE: assert property (@(posedge clk) disable iff (rst)
        (!bus_oe_n || !bus_we_n) |-> !bus_ce_n); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        (bus_doe && $past(bus_doe)) |-> $stable(bus_dout)); // R8
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(bus_addr)); // R9
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cfg_region_en) |=> !busy); // R10
endmodule

// File: tb/extbus_cycle_gen_tb_top.sv
`timescale 1ns/1ps
module extbus_cycle_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_region_en = 1'b1;
    logic        cfg_ack_en = 1'b0;
    logic [1:0]  cfg_scale = 2'd1;
    logic        cfg_rdy_en = 1'b0;
    logic [3:0]  cfg_lead = '0, cfg_setup = '0, cfg_rd_pulse = '0, cfg_wr_pulse = '0;
    logic [3:0]  cfg_rd_tail = '0, cfg_wr_tail = '0, cfg_gap = '0, cfg_rdy_tail = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        busy, done;
    logic [15:0] rdata;
    logic        bus_ce_n, bus_oe_n, bus_we_n, bus_ack_n, bus_doe;
    logic [15:0] bus_addr, bus_dout;
    logic [15:0] bus_din = '0;
    logic        bus_ready = 1'b1;

    int tests = 0;
    int fails = 0;
    logic [15:0] last_rd = '0;

    always #10 clk = ~clk;

    extbus_cycle_gen dut_i (
        .clk(clk), .rst(rst),
        .cfg_region_en(cfg_region_en), .cfg_ack_en(cfg_ack_en), .cfg_scale(cfg_scale),
        .cfg_rdy_en(cfg_rdy_en), .cfg_lead(cfg_lead), .cfg_setup(cfg_setup),
        .cfg_rd_pulse(cfg_rd_pulse), .cfg_wr_pulse(cfg_wr_pulse),
        .cfg_rd_tail(cfg_rd_tail), .cfg_wr_tail(cfg_wr_tail), .cfg_gap(cfg_gap),
        .cfg_rdy_tail(cfg_rdy_tail),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata),
        .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_ack_n(bus_ack_n),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din), .bus_ready(bus_ready)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int mult_of(input logic [1:0] c);
        case (c)
            2'd0: return 4;
            2'd1: return 1;
            2'd2: return 2;
            default: return 8;
        endcase
    endfunction

    // rdy_mode: 0 ready high, 1 low then raised at strobe clock rdy_k, 2 low throughout
    task automatic run_txn(input logic wr, input logic [15:0] a, input logic [15:0] d,
                           input int rdy_mode, input int rdy_k, input int poke, input string stb_tag);
        int m, s_len, stb_exp, w_len, a_len, c_len, h_len, g_len;
        int idx, n_ce, n_stb, n_wrong, n_doe, n_dout_bad, n_addr_bad, n_done, done_idx, n_ack;
        logic stb, wrong;
        m       = mult_of(cfg_scale);
        a_len   = cfg_lead * m;
        c_len   = cfg_setup * m;
        s_len   = ((wr ? cfg_wr_pulse : cfg_rd_pulse) + 1) * m;
        stb_exp = s_len;
        if (cfg_rdy_en && rdy_mode == 1 && rdy_k + 3 > s_len) stb_exp = rdy_k + 3;
        w_len   = cfg_rdy_en ? cfg_rdy_tail * m : 0;
        h_len   = ((wr ? cfg_wr_tail : cfg_rd_tail) + 1) * m;
        g_len   = (cfg_gap + 1) * m;
        idx = 0; n_ce = 0; n_stb = 0; n_wrong = 0; n_doe = 0; n_dout_bad = 0;
        n_addr_bad = 0; n_done = 0; done_idx = -1; n_ack = 0;

        @(negedge clk);
        bus_ready = (rdy_mode == 0);
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy && idx < 4000) begin
            stb   = wr ? !bus_we_n : !bus_oe_n;
            wrong = wr ? !bus_oe_n : !bus_we_n;
            if (!bus_ce_n) n_ce++;
            if (stb) begin
                if (rdy_mode == 1 && n_stb == rdy_k) bus_ready = 1'b1;
                n_stb++;
            end
            if (wrong) n_wrong++;
            bus_din = !bus_oe_n ? (a ^ 16'h5A3C) : 16'h0000;
            if (bus_doe) begin
                n_doe++;
                if (bus_dout !== d) n_dout_bad++;
            end
            if (bus_addr !== a) n_addr_bad++;
            if (done) begin n_done++; done_idx = idx; end
            if (!bus_ack_n) n_ack++;
            if (idx == poke) begin
                req_valid = 1'b1; req_addr = ~a; req_write = !wr;
            end else begin
                req_valid = 1'b0;
            end
            idx++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk("R1 busy clocks", idx, a_len + c_len + stb_exp + w_len + h_len + g_len);
        chk("R2 chip enable clocks", n_ce, c_len + stb_exp + w_len + h_len);
        chk(stb_tag, n_stb, stb_exp + w_len);
        chk("R3 other strobe clocks", n_wrong, 0);
        chk("R7 done index", done_idx, a_len + c_len + stb_exp + w_len + h_len);
        chk("R7 done count", n_done, 1);
        chk("R8 drive enable clocks", n_doe, wr ? (c_len + stb_exp + w_len + h_len) : 0);
        chk("R8 write data mismatches", n_dout_bad, 0);
        chk("R9 address mismatches", n_addr_bad, 0);
        chk("R11 ack clocks", n_ack, cfg_ack_en ? (c_len + stb_exp + w_len + h_len) : 0);
        if (!wr) last_rd = a ^ 16'h5A3C;
        chk("R6 read data", int'(rdata), int'(last_rd));
        @(negedge clk);
        chk("R12 no follow-up cycle", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 busy", int'(busy), 0);
        chk("R13 done", int'(done), 0);
        chk("R13 strobes", int'({bus_ce_n, bus_oe_n, bus_we_n, bus_ack_n}), 15);
        chk("R13 doe", int'(bus_doe), 0);
        chk("R13 rdata", int'(rdata), 0);
        rst = 1'b0;
        @(negedge clk);

        // R1 R2 R3 sweep over scale codes, directions and field sets
        for (int c = 0; c < 4; c++) begin
            for (int w = 0; w < 2; w++) begin
                for (int s = 0; s < 4; s++) begin
                    cfg_scale    = 2'(c);
                    cfg_lead     = 4'(s);
                    cfg_setup    = 4'((s * 3) % 4);
                    cfg_rd_pulse = 4'((s * 5 + 1) % 16);
                    cfg_wr_pulse = 4'((s * 7 + 2) % 16);
                    cfg_rd_tail  = 4'(s);
                    cfg_wr_tail  = 4'(3 - s);
                    cfg_gap      = 4'((s * 2) % 5);
                    cfg_ack_en   = s[0];
                    run_txn(w[0], 16'(c * 256 + w * 16 + s + 16'h1200), 16'(16'hC0DE ^ (c * 97 + s)),
                            0, 0, -1, "R3 strobe clocks");
                end
            end
        end

        // R4 ready stretch
        cfg_scale = 2'd1; cfg_lead = 4'd1; cfg_setup = 4'd1; cfg_rd_pulse = 4'd2; cfg_wr_pulse = 4'd2;
        cfg_rd_tail = 4'd0; cfg_wr_tail = 4'd1; cfg_gap = 4'd0; cfg_ack_en = 1'b0;
        cfg_rdy_en = 1'b1; cfg_rdy_tail = 4'd2;
        run_txn(1'b0, 16'h0A11, 16'h0, 1, 6, -1, "R4 stretched read strobe");
        run_txn(1'b1, 16'h0A12, 16'h3344, 1, 9, -1, "R4 stretched write strobe");
        cfg_scale = 2'd2; cfg_rdy_tail = 4'd0;
        run_txn(1'b0, 16'h0A13, 16'h0, 1, 0, -1, "R4 ready before strobe end");
        run_txn(1'b0, 16'h0A14, 16'h0, 0, 0, -1, "R4 ready already high");

        // R5 ready ignored when ready mode off
        cfg_rdy_en = 1'b0; cfg_rdy_tail = 4'd3;
        run_txn(1'b0, 16'h0B01, 16'h0, 2, 0, -1, "R5 strobe with ready low");
        run_txn(1'b1, 16'h0B02, 16'h7788, 2, 0, -1, "R5 write with ready low");

        // R12 request while busy
        cfg_scale = 2'd1; cfg_rd_pulse = 4'd5;
        run_txn(1'b0, 16'h0C01, 16'h0, 0, 0, 2, "R12 strobe clocks");
        run_txn(1'b1, 16'h0C02, 16'hBEEF, 0, 0, 4, "R12 strobe clocks write");

        // R10 disabled region
        begin
            int n_act;
            n_act = 0;
            cfg_region_en = 1'b0;
            @(negedge clk);
            req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0D00;
            @(negedge clk);
            req_valid = 1'b0;
            for (int i = 0; i < 20; i++) begin
                if (busy || !bus_ce_n || done) n_act++;
                @(negedge clk);
            end
            chk("R10 activity while disabled", n_act, 0);
            chk("R10 read data untouched", int'(rdata), int'(last_rd));
            cfg_region_en = 1'b1;
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule